// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block decides when an external bus access may finish. When an access begins, it loads a small down-counter with a software-set wait count. It then merges the counter's own ready indication with an external ready line. Which of four ways it uses to merge them is programmable. Every ready signal is active low: 0 means ready and 1 means hold the access. The block drives an internal ready output that holds the current access while it is 1. It also gives a one-cycle completion pulse in the cycle the access may end.

The wait count (3 bits) and the merge mode (2 bits) sit in a small configuration register. Software writes that register through a single write strobe. The register values are copied into the access logic only when an access starts. A bus controller pulses `access_start` to open an access. It keeps the access open until `acc_done` is seen.

Top module: `wait_state_gen`

## Requirements
- R1: After reset the stored wait count is 7 and the stored mode is AND-combined (10). `rdy_int_n` is 1 and `acc_done` is 0. An access started after reset, with `ext_rdy_n` held at 0, therefore spends 7 held cycles and completes in the 8th cycle after the start edge.
- R2: A high `access_start` sampled while no access is open opens an access. It loads the counter with the stored wait count and latches the stored mode. A high `access_start` sampled while an access is open is ignored.
- R3: While an access is open and not completing, the counter drops by one each clock until it reaches 0. It then stays at 0 until the next access start. The counter-derived ready is 1 while the counter is nonzero and 0 once it is zero.
- R4: Mode 00 (external only): during an access, `rdy_int_n` equals `ext_rdy_n`, whatever the counter holds.
- R5: Mode 01 (counter only): during an access, `rdy_int_n` equals the counter-derived ready, and `ext_rdy_n` has no effect.
- R6: Mode 10 (AND-combined): during an access, `rdy_int_n` is 0 only when both `ext_rdy_n` and the counter-derived ready are 0.
- R7: Mode 11 (OR-combined): during an access, `rdy_int_n` is 0 when either `ext_rdy_n` or the counter-derived ready is 0.
- R8: `acc_done` is 1 exactly in a cycle where an access is open and `rdy_int_n` is 0, and the access closes at the following edge. While no access is open, `rdy_int_n` is 1 and `acc_done` is 0.
- R9: A configuration write (`cfg_we` high) updates the stored count and mode at the clock edge. The write does not change an access already open. A write sampled at the same edge as an access start applies from the following access onward.
- R10: A wait count of 0 in counter-only mode completes the access in the first cycle after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_cnt | input | 3 | Wait count to store (0 to 7) |
| cfg_mode | input | 2 | Merge mode to store: 00 external, 01 counter, 10 AND, 11 OR |
| access_start | input | 1 | Opens an access when no access is open |
| ext_rdy_n | input | 1 | External ready, 0 = ready |
| rdy_int_n | output | 1 | Internal ready, 1 = hold access, 0 = complete |
| acc_done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a configuration write that lands while an access is still open, or at the very edge that opens one. The open access must keep its latched count and mode, and the next access must pick up the new values. Directed sequences place writes at the start edge and in the middle of long counter-held accesses. A long random phase then mixes writes, starts and external ready toggling on every cycle. A behavioural model scores `rdy_int_n` and `acc_done` after every one of those cycles. In AND mode the stimulus also holds the external line not-ready well past the counter's expiry, so that the counter's hold at zero is exercised.

// File: rtl/ws_pkg.sv
package ws_pkg;
    typedef enum logic [1:0] {
        MODE_EXT = 2'b00,
        MODE_CNT = 2'b01,
        MODE_AND = 2'b10,
        MODE_OR  = 2'b11
    } ws_mode_e;
endpackage

// File: rtl/ws_cfg_reg.sv
module ws_cfg_reg
    import ws_pkg::*;
#(
    parameter int       CNT_W    = 3,
    parameter int       RST_CNT  = 7,
    parameter ws_mode_e RST_MODE = MODE_AND
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic [1:0]       mode_in,
    output logic [CNT_W-1:0] cnt_out,
    output ws_mode_e         mode_out
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        ws_mode_e         mode;
    } cfg_t;

    cfg_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (we) begin
            reg_d.cnt  = cnt_in;
            reg_d.mode = ws_mode_e'(mode_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q.cnt  <= CNT_W'(RST_CNT);
            reg_q.mode <= RST_MODE;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign cnt_out  = reg_q.cnt;
    assign mode_out = reg_q.mode;
endmodule

// File: rtl/ws_down_counter.sv
module ws_down_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             wait_n
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && (cnt_q != ZERO)) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= ZERO;
        else        cnt_q <= cnt_d;
    end

    assign cnt    = cnt_q;
    assign wait_n = (cnt_q != ZERO);
endmodule

// File: rtl/ws_ready_mux.sv
module ws_ready_mux
    import ws_pkg::*;
(
    input  ws_mode_e mode,
    input  logic     ext_n,
    input  logic     cnt_n,
    output logic     rdy_n
);
    always_comb begin
        unique case (mode)
            MODE_EXT: rdy_n = ext_n;
            MODE_CNT: rdy_n = cnt_n;
            MODE_AND: rdy_n = ext_n | cnt_n;
            MODE_OR:  rdy_n = ext_n & cnt_n;
            default:  rdy_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen
    import ws_pkg::*;
#(
    parameter int       CNT_W    = 3,
    parameter int       RST_CNT  = 7,
    parameter ws_mode_e RST_MODE = MODE_AND
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_cnt,
    input  logic [1:0]       cfg_mode,
    input  logic             access_start,
    input  logic             ext_rdy_n,
    output logic             rdy_int_n,
    output logic             acc_done
);
    typedef struct packed {
        logic     active;
        ws_mode_e mode;
    } acc_t;

    acc_t st_d, st_q;

    logic [CNT_W-1:0] cfg_cnt_q;
    ws_mode_e         cfg_mode_q;
    logic [CNT_W-1:0] wcnt_q;
    logic             cnt_wait_n;
    logic             mux_rdy_n;
    logic             start_go;
    logic             active_q;
    logic [1:0]       amode_q;

    ws_cfg_reg #(
        .CNT_W   (CNT_W),
        .RST_CNT (RST_CNT),
        .RST_MODE(RST_MODE)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .cnt_in  (cfg_cnt),
        .mode_in (cfg_mode),
        .cnt_out (cfg_cnt_q),
        .mode_out(cfg_mode_q)
    );

    assign start_go = access_start && !st_q.active;

    ws_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start_go),
        .load_val(cfg_cnt_q),
        .run     (st_q.active),
        .cnt     (wcnt_q),
        .wait_n  (cnt_wait_n)
    );

    ws_ready_mux u_mux (
        .mode (st_q.mode),
        .ext_n(ext_rdy_n),
        .cnt_n(cnt_wait_n),
        .rdy_n(mux_rdy_n)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (!mux_rdy_n) st_d.active = 1'b0;
        end else if (start_go) begin
            st_d.active = 1'b1;
            st_d.mode   = cfg_mode_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.active <= 1'b0;
            st_q.mode   <= RST_MODE;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_q  = st_q.active;
    assign amode_q   = st_q.mode;
    assign rdy_int_n = st_q.active ? mux_rdy_n : 1'b1;
    assign acc_done  = st_q.active & ~mux_rdy_n;
endmodule

// File: rtl/ws_checker.sv
module ws_checker #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             access_start,
    input logic             ext_rdy_n,
    input logic             rdy_int_n,
    input logic             acc_done,
    input logic             active,
    input logic [1:0]       amode,
    input logic [CNT_W-1:0] wcnt,
    input logic [CNT_W-1:0] cfg_cnt_q
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && access_start) |=> (active && wcnt == $past(cfg_cnt_q))); // R2

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rdy_int_n) |=> (active && $stable(amode))); // R2

    AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rdy_int_n && wcnt != ZERO) |=> (wcnt == $past(wcnt) - ONE)); // R3

    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rdy_int_n && wcnt == ZERO) |=> (wcnt == ZERO)); // R3

    AST_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (active && amode == 2'b00) |-> (rdy_int_n == ext_rdy_n)); // R4

    AST_CNT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (active && amode == 2'b01) |-> (rdy_int_n == (wcnt != ZERO))); // R5

    AST_AND_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (active && amode == 2'b10 && ext_rdy_n) |-> !acc_done); // R6

    AST_OR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && amode == 2'b11 && !ext_rdy_n) |-> acc_done); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> (!acc_done && !active)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (rdy_int_n && !acc_done)); // R8
endmodule

bind wait_state_gen ws_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .access_start(access_start),
    .ext_rdy_n   (ext_rdy_n),
    .rdy_int_n   (rdy_int_n),
    .acc_done    (acc_done),
    .active      (active_q),
    .amode       (amode_q),
    .wcnt        (wcnt_q),
    .cfg_cnt_q   (cfg_cnt_q)
);

// File: tb/sim_wait_state_gen.sv
`timescale 1ns/1ps
module sim_wait_state_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_cnt = '0;
    logic [1:0] cfg_mode = '0;
    logic       access_start = 1'b0;
    logic       ext_rdy_n = 1'b1;
    logic       rdy_int_n;
    logic       acc_done;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit last_done;

    // behavioural reference state
    int m_cfg_cnt, m_cfg_mode, m_act, m_wcnt, m_mode;

    always #10 clk = ~clk;

    wait_state_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cnt(cfg_cnt),
        .cfg_mode(cfg_mode), .access_start(access_start),
        .ext_rdy_n(ext_rdy_n), .rdy_int_n(rdy_int_n), .acc_done(acc_done)
    );

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int model_rdy(int ext);
        int wt;
        if (m_act == 0) return 1;
        wt = (m_wcnt != 0) ? 1 : 0;
        case (m_mode)
            0: return ext;
            1: return wt;
            2: return ext | wt;
            default: return ext & wt;
        endcase
    endfunction

    // one clock: drive inputs, compare outputs, advance model past the edge
    task automatic step(string req, bit st, bit ext, bit we = 0, int cnt = 0, int md = 0);
        int er, ed;
        @(negedge clk);
        access_start = st; ext_rdy_n = ext; cfg_we = we;
        cfg_cnt = 3'(cnt); cfg_mode = 2'(md);
        #1;
        er = model_rdy(ext);
        ed = (m_act != 0 && er == 0) ? 1 : 0;
        check(req, "rdy_int_n", int'(rdy_int_n), er);
        check(req, "acc_done", int'(acc_done), ed);
        last_done = acc_done;
        if (m_act != 0) begin
            if (er == 0) m_act = 0;
            else if (m_wcnt != 0) m_wcnt--;
        end else if (st) begin
            m_act = 1; m_wcnt = m_cfg_cnt; m_mode = m_cfg_mode;
        end
        if (we) begin
            m_cfg_cnt = cnt; m_cfg_mode = md;
        end
    endtask

    task automatic cfg(int cnt, int md);
        step("R9", 0, 1, 1, cnt, md);
    endtask

    // start an access, run until done, return cycles from start edge to done
    task automatic run_acc(string req, bit ext, output int n);
        n = 0;
        step(req, 1, ext);
        do begin
            step(req, 0, ext);
            n++;
        end while (!last_done && n < 20);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int n;
        m_cfg_cnt = 7; m_cfg_mode = 2; m_act = 0; m_wcnt = 0; m_mode = 2;
        repeat (3) @(negedge clk);
        #1;
        check("R1", "reset rdy_int_n", int'(rdy_int_n), 1);
        check("R1", "reset acc_done", int'(acc_done), 0);
        rst_n = 1'b1;
        step("R8", 0, 0);

        // R1: reset defaults give seven holds in AND mode
        run_acc("R1", 0, n);
        check("R1", "cycles to done", n, 8);
        step("R8", 0, 0);

        // R4: external only, counter ignored
        cfg(5, 0);
        step("R4", 1, 1);
        for (int i = 0; i < 3; i++) step("R4", 0, 1);
        step("R4", 0, 0);
        step("R4", 1, 0);
        step("R4", 0, 0);

        // R5: counter only, external toggles ignored
        cfg(3, 1);
        step("R5", 1, 0);
        for (int i = 0; i < 4; i++) step("R5", 0, i[0]);
        run_acc("R5", 1, n);
        check("R5", "cycles to done", n, 4);

        // R10: zero count, counter only
        cfg(0, 1);
        run_acc("R10", 1, n);
        check("R10", "cycles to done", n, 1);

        // R6 and R3: AND, external late, counter holds at zero
        cfg(2, 2);
        step("R6", 1, 1);
        for (int i = 0; i < 6; i++) step("R3", 0, 1);
        step("R6", 0, 0);
        cfg(4, 2);
        run_acc("R6", 0, n);
        check("R6", "cycles to done", n, 5);

        // R7: OR, external early or never
        cfg(6, 3);
        step("R7", 1, 1);
        step("R7", 0, 1);
        step("R7", 0, 0);
        run_acc("R7", 1, n);
        check("R7", "cycles to done", n, 7);

        // R2: start during open access ignored
        cfg(3, 1);
        step("R2", 1, 1);
        step("R2", 1, 1);
        step("R2", 1, 1);
        step("R2", 0, 1);
        step("R2", 0, 1);
        step("R2", 0, 1);

        // R9: write mid-access and at start edge
        cfg(5, 1);
        step("R9", 1, 1);
        step("R9", 0, 1, 1, 1, 0);
        for (int i = 0; i < 5; i++) step("R9", 0, 1);
        run_acc("R9", 1, n);
        check("R9", "new mode ext-only hold", n, 20);
        step("R9", 0, 0);
        step("R9", 0, 0, 1, 2, 1);
        step("R9", 1, 1, 1, 6, 1);
        step("R9", 0, 1);
        step("R9", 0, 1);
        step("R9", 0, 1);
        run_acc("R9", 1, n);
        check("R9", "count after same-edge write", n, 7);

        // random mix of everything
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom;
            step("R8", r[0], r[1], (r[7:4] == 0), r[10:8], r[12:11]);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule